// File: doc/BRIEF.md
# Prescaled Reloading Interval Timer

This block produces a periodic interrupt. A prescaler divides the clock by a programmable amount, and each prescaler tick steps a 16-bit down-counter by one. When a tick finds the counter at zero, the timer emits a one-cycle interrupt pulse and refills the counter from a period register. The result is a fixed repeat interval of (period+1)×(scale+1) clock cycles.

Software controls the timer through a simple register write port. It can load the counter directly, which sets the length of the first interval independently of the period. It also sets the reload period and the 8-bit prescale value. An enable input freezes and resumes the timer. The live counter value can be read back at all times.

Top module: `interval_timer`

## Requirements
- R1: While and after synchronous reset, `count_o` is 0 and `irq_o` is 0.
- R2: A write takes effect at the clock edge where `wr_en` is high. `wr_sel` chooses the target: 0 loads the counter from `wr_data`, and the new value shows on `count_o` after that edge. 1 sets the reload period. 2 sets the prescale value from the low 8 bits of `wr_data`.
- R3: With a prescale value s, the counter moves once every s+1 enabled cycles, so s = 0 moves it every cycle.
- R4: Each tick lowers a nonzero counter by exactly one. A tick that finds the counter at zero reloads it with the period value.
- R5: With the counter loaded to P, the period set to P and the prescale set to S, the first interrupt comes (P+1)×(S+1) cycles after the enable rises. Every later interrupt follows the previous one by the same number of cycles.
- R6: `irq_o` is high for exactly the one cycle after the reload edge. When the interval exceeds one cycle, it is low in the next cycle.
- R7: While `enable` is low, the counter and prescaler hold their values. On the cycle `enable` rises, the prescaler restarts from its full count, so the first tick lands on the (s+1)th enabled cycle, counting the rising cycle.
- R8: A counter write in the same cycle as a tick wins. The written value is loaded, no reload takes place and no interrupt is raised.
- R9: A new period does not disturb the countdown in progress. It is used at the next reload.
- R10: A write with `wr_sel` = 3 changes neither the counter, the period nor the prescale value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 counter, 1 period, 2 prescale, 3 none |
| wr_data | input | 16 | Write data |
| enable | input | 1 | Run when high, freeze when low |
| count_o | output | 16 | Current counter value |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The bench measures intervals between pulses for directed and random period/prescale pairs. An off-by-one in either the prescaler or the counter would show up as an interval that is too short or too long by a whole factor. It pauses the timer part-way through a prescale run and checks that the first step after resuming comes a full prescale later. A design that resumed the partial count would step early. It also collides a counter write with a reload tick; a design that let the tick win would pulse the interrupt or load the period instead. A period change in mid-count and a write to the unused select complete the set; a broken design would cut the running interval short or change the timing.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef enum logic [1:0] {
    SEL_COUNT  = 2'd0,
    SEL_PERIOD = 2'd1,
    SEL_SCALE  = 2'd2,
    SEL_NONE   = 2'd3
  } timer_sel_e;
endpackage

// File: rtl/timer_regs.sv
module timer_regs #(
  parameter int CNT_W   = 16,
  parameter int SCALE_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [CNT_W-1:0]   wr_data,
  output logic [CNT_W-1:0]   period_q,
  output logic [SCALE_W-1:0] scale_q,
  output logic               load_o,
  output logic [CNT_W-1:0]   load_val_o
);
  import timer_pkg::*;

  assign load_o     = wr_en && (timer_sel_e'(wr_sel) == SEL_COUNT);
  assign load_val_o = wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= '0;
      scale_q  <= '0;
    end else if (wr_en) begin
      if (timer_sel_e'(wr_sel) == SEL_PERIOD) period_q <= wr_data;
      if (timer_sel_e'(wr_sel) == SEL_SCALE)  scale_q  <= wr_data[SCALE_W-1:0];
    end
  end

  assert_spare_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd3) |=> ($stable(period_q) && $stable(scale_q)));
endmodule

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
  parameter int SCALE_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [SCALE_W-1:0] scale,
  output logic               tick_o
);
  logic [SCALE_W-1:0] remain_q;
  logic [SCALE_W-1:0] remain_eff;
  logic               en_q;

  // on the rising cycle of the enable the prescaler starts a fresh run
  assign remain_eff = (en && !en_q) ? scale : remain_q;
  assign tick_o     = en && (remain_eff == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
      en_q     <= 1'b0;
    end else begin
      en_q <= en;
      if (en) remain_q <= (remain_eff == '0) ? scale : remain_eff - 1'b1;
    end
  end

  assert_frozen_prescale_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(remain_q));
  assert_tick_only_enabled_R3: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> en);
endmodule

// File: rtl/timer_down_counter.sv
module timer_down_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt_q,
  output logic             irq_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (load) begin
        cnt_q <= load_val;
      end else if (tick) begin
        if (cnt_q == '0) begin
          cnt_q <= period;
          irq_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assert_irq_with_reload_R4: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (cnt_q == $past(period)));
  assert_single_step_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  assert_write_wins_R8: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == $past(load_val) && !irq_q));
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> ($stable(cnt_q) && !irq_q));
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int CNT_W   = 16,
  parameter int SCALE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             enable,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o
);
  logic [CNT_W-1:0]   period_q;
  logic [SCALE_W-1:0] scale_q;
  logic               load;
  logic [CNT_W-1:0]   load_val;
  logic               tick;

  timer_regs #(.CNT_W(CNT_W), .SCALE_W(SCALE_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .period_q(period_q), .scale_q(scale_q), .load_o(load), .load_val_o(load_val)
  );

  timer_prescaler #(.SCALE_W(SCALE_W)) u_pre (
    .clk(clk), .rst(rst), .en(enable), .scale(scale_q), .tick_o(tick)
  );

  timer_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .load(load), .load_val(load_val),
    .period(period_q), .cnt_q(count_o), .irq_q(irq_o)
  );

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (count_o == '0 && !irq_o));
endmodule

// File: tb/test_interval_timer.sv
module test_interval_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        enable = 1'b0;
  logic [15:0] count_o;
  logic        irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  interval_timer i_interval_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .enable(enable), .count_o(count_o), .irq_o(irq_o)
  );

  function automatic int exp_interval(int p, int s);
    return (p + 1) * (s + 1);
  endfunction

  task automatic check(bit ok, string req, int actual, int expected);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [1:0] sel, logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    do begin step(); n++; end while (!irq_o && n < 70000);
  endtask

  task automatic run_interval(int p, int s);
    int n1, n2, e;
    enable = 1'b0;
    wr(2'd0, 16'(p)); wr(2'd1, 16'(p)); wr(2'd2, 16'(s));
    e = exp_interval(p, s);
    enable = 1'b1;
    wait_irq(n1);
    check(n1 == e, "R5 first interval", n1, e);
    if (e > 1) begin
      step();
      check(irq_o == 1'b0, "R6 pulse width", irq_o, 0);
      wait_irq(n2);
      n2 = n2 + 1;
    end else begin
      wait_irq(n2);
    end
    check(n2 == e, "R5 repeat interval", n2, e);
    enable = 1'b0;
    step();
  endtask

  initial begin
    int n, e;
    void'($urandom(32'd1234));
    step(); step();
    check(count_o == 16'd0, "R1 count after reset", count_o, 0);
    check(irq_o == 1'b0, "R1 irq after reset", irq_o, 0);
    rst = 1'b0;
    step();

    // R2 direct counter write visible next cycle
    wr(2'd0, 16'hA5C3);
    check(count_o == 16'hA5C3, "R2 counter write", count_o, 16'hA5C3);

    // R3 prescale 2: moves every third cycle
    wr(2'd0, 16'd10); wr(2'd2, 16'h0302);
    enable = 1'b1;
    step(); step();
    check(count_o == 16'd10, "R3 no step before s+1", count_o, 10);
    step();
    check(count_o == 16'd9, "R3 first step", count_o, 9);
    step(); step(); step();
    check(count_o == 16'd8, "R3 second step", count_o, 8);
    enable = 1'b0;
    step();

    // R7 pause mid prescale run, resume restarts the full count
    wr(2'd0, 16'd20); wr(2'd2, 16'd3);
    enable = 1'b1; step(); step();
    enable = 1'b0;
    for (int i = 0; i < 5; i++) step();
    check(count_o == 16'd20, "R7 hold while disabled", count_o, 20);
    enable = 1'b1;
    step(); step(); step();
    check(count_o == 16'd20, "R7 restart full prescale", count_o, 20);
    step();
    check(count_o == 16'd19, "R7 first step after resume", count_o, 19);
    enable = 1'b0;
    step();

    // R4 reload and interval with directed corners
    run_interval(0, 0);
    run_interval(3, 0);
    run_interval(0, 4);
    run_interval(5, 2);
    run_interval(2, 255);

    // R4 reload value after zero
    wr(2'd0, 16'd0); wr(2'd1, 16'd77); wr(2'd2, 16'd0);
    enable = 1'b1; step();
    check(irq_o == 1'b1, "R4 irq at zero", irq_o, 1);
    check(count_o == 16'd77, "R4 reload value", count_o, 77);
    enable = 1'b0; step();

    // R8 write collides with zero tick
    wr(2'd0, 16'd0); wr(2'd1, 16'd5);
    enable = 1'b1; wr_en = 1'b1; wr_sel = 2'd0; wr_data = 16'd9;
    step();
    wr_en = 1'b0;
    check(count_o == 16'd9, "R8 write wins", count_o, 9);
    check(irq_o == 1'b0, "R8 no irq on collision", irq_o, 0);
    enable = 1'b0; step();

    // R9 period change mid count
    wr(2'd0, 16'd3); wr(2'd1, 16'd3); wr(2'd2, 16'd0);
    enable = 1'b1; step();
    wr_en = 1'b1; wr_sel = 2'd1; wr_data = 16'd7; step(); wr_en = 1'b0;
    wait_irq(n); n = n + 2;
    check(n == 4, "R9 current interval kept", n, 4);
    wait_irq(n);
    check(n == 8, "R9 new period used", n, 8);
    enable = 1'b0; step();

    // R10 spare select ignored
    wr(2'd0, 16'd4); wr(2'd1, 16'd4); wr(2'd2, 16'd1);
    wr(2'd3, 16'hFFFF);
    check(count_o == 16'd4, "R10 counter untouched", count_o, 4);
    enable = 1'b1;
    wait_irq(n);
    e = exp_interval(4, 1);
    check(n == e, "R10 period and scale untouched", n, e);
    enable = 1'b0; step();

    // random settings
    for (int k = 0; k < 6; k++) begin
      run_interval(int'($urandom % 41), int'($urandom % 8));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 190000; c++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule